// File: doc/BRIEF.md
# Multi-source configurable I/O port

This block is an eight-pin general-purpose port that sits beside a small processor and a programmable logic array. Every pin picks its own output source through a two-bit field in a control register: the port's data register, one bit of an address captured from a multiplexed bus, one macrocell output of the logic array, or (on the two lowest pins only) an external chip-select line. A per-pin direction bit decides whether the pin drives. In macrocell mode, the array's product-term enable also has to be high for the pin to drive.

The processor reaches the port through a small register bus. It writes the control, data and direction registers. It reads back one source at a time: the synchronised pin levels, any of the three writable registers, or the macrocell outputs. Address bits reach the pins through a transparent capture stage. The stage follows the bus while the latch-enable strobe is high and keeps its value once the strobe drops.

The read path is a single registered multiplexer, so the block has no state machine beyond its registers.

Top module: `mio_port`

## Requirements
- R1: While reset is asserted and after it is released, every output enable is 0, read data is 0, and the control, data and direction registers, the captured address and the synchroniser all hold 0.
- R2: A write strobe loads the 16-bit control register at offset 1 (pin i uses bits 2i+1:2i), the data register at offset 2 (wdata[7:0]) and the direction register at offset 3 (wdata[7:0]). On the clock edge that samples a read strobe, read data takes the value at the given offset. Eight-bit values return zero-extended. Read data holds whenever no read strobe is sampled.
- R3: Writes to offsets 0, 4, 5, 6 and 7 change no register.
- R4: Reads of offsets 5, 6 and 7 return zero.
- R5: In modes other than macrocell, pin_oe[i] equals direction bit i.
- R6: Field value 00 drives the data register bit onto the pin.
- R7: Field value 01 drives the captured address bit. The capture follows mux_addr while ale is 1, and keeps the value sampled on the last clock edge with ale high once ale is 0.
- R8: Field value 10 drives mc_out[i], and pin_oe[i] is direction bit i ANDed with mc_oe[i].
- R9: Field value 11 drives ext_cs[0] on pin 0 and ext_cs[1] on pin 1. On pins 2 to 7 it drives the data register bit.
- R10: A read of offset 0 returns pin_in after a two-flop synchroniser. A read of offset 4 returns mc_out as sampled on the read edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ale | input | 1 | Address latch enable |
| mux_addr | input | 8 | Multiplexed address bits for the pins |
| mc_out | input | 8 | Macrocell outputs |
| mc_oe | input | 8 | Product-term output enables |
| ext_cs | input | 2 | External chip selects for pins 0 and 1 |
| pin_in | input | 8 | Pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |

## Verification
Three timings have to be honoured. Pin outputs and enables are combinational in the registers and inputs, so a register write shows on the pins just after the edge that samples it. A change on mux_addr, mc_out, mc_oe or ext_cs shows on the pins in the same cycle. Read data appears on the edge that samples the read strobe, and a new pin level needs two further edges before a read can see it. The bench drives inputs on falling edges and samples 1 ns after a rising edge. A behavioural reference model updates on each rising edge, and the bench compares against it every cycle. Directed checks read the pins in a read of offset 0 on the third edge after the pin change.

// File: rtl/mio_pkg.sv
`timescale 1ns/1ps
package mio_pkg;
    typedef enum logic [1:0] {
        SRC_DOUT  = 2'b00,
        SRC_ADDR  = 2'b01,
        SRC_MCELL = 2'b10,
        SRC_XCS   = 2'b11
    } src_e;

    localparam int OFF_PIN  = 0;
    localparam int OFF_CTRL = 1;
    localparam int OFF_DOUT = 2;
    localparam int OFF_DIR  = 3;
    localparam int OFF_MC   = 4;
endpackage

// File: rtl/mio_sync.sv
`timescale 1ns/1ps
module mio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mio_addr_latch.sv
`timescale 1ns/1ps
module mio_addr_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ale,
    input  logic [W-1:0] addr_in,
    output logic [W-1:0] addr_out
);
    logic [W-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   held_q <= '0;
        else if (ale) held_q <= addr_in;
    end

    // transparent while the strobe is high, holds afterwards
    assign addr_out = ale ? addr_in : held_q;
endmodule

// File: rtl/mio_regs.sv
`timescale 1ns/1ps
module mio_regs import mio_pkg::*; #(
    parameter int PORT_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [2*PORT_W-1:0]   bus_wdata,
    input  logic [PORT_W-1:0]     pin_sync,
    input  logic [PORT_W-1:0]     mc_out,
    output logic [2*PORT_W-1:0]   ctrl_q,
    output logic [PORT_W-1:0]     dout_q,
    output logic [PORT_W-1:0]     dir_q,
    output logic [2*PORT_W-1:0]   bus_rdata
);
    localparam int BUS_W = 2 * PORT_W;
    localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(OFF_PIN);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(OFF_DOUT);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFF_DIR);
    localparam logic [ADDR_W-1:0] A_MC   = ADDR_W'(OFF_MC);

    logic [BUS_W-1:0] rd_mux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            dout_q <= '0;
            dir_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL:  ctrl_q <= bus_wdata;
                A_DOUT:  dout_q <= bus_wdata[PORT_W-1:0];
                A_DIR:   dir_q  <= bus_wdata[PORT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            A_PIN:   rd_mux = BUS_W'(pin_sync);
            A_CTRL:  rd_mux = ctrl_q;
            A_DOUT:  rd_mux = BUS_W'(dout_q);
            A_DIR:   rd_mux = BUS_W'(dir_q);
            A_MC:    rd_mux = BUS_W'(mc_out);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/mio_pinmux.sv
`timescale 1ns/1ps
module mio_pinmux import mio_pkg::*; #(
    parameter int PORT_W = 8,
    parameter int XCS_W  = 2
) (
    input  logic [2*PORT_W-1:0] ctrl,
    input  logic [PORT_W-1:0]   dout,
    input  logic [PORT_W-1:0]   dir,
    input  logic [PORT_W-1:0]   lat_addr,
    input  logic [PORT_W-1:0]   mc_out,
    input  logic [PORT_W-1:0]   mc_oe,
    input  logic [XCS_W-1:0]    ext_cs,
    output logic [PORT_W-1:0]   pin_out,
    output logic [PORT_W-1:0]   pin_oe
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        src_e sel;
        logic xcs_bit;

        assign sel = src_e'(ctrl[2*i +: 2]);

        if (i < XCS_W) begin : g_xcs
            assign xcs_bit = ext_cs[i];
        end else begin : g_fallback
            assign xcs_bit = dout[i];
        end

        always_comb begin
            unique case (sel)
                SRC_DOUT:  pin_out[i] = dout[i];
                SRC_ADDR:  pin_out[i] = lat_addr[i];
                SRC_MCELL: pin_out[i] = mc_out[i];
                SRC_XCS:   pin_out[i] = xcs_bit;
            endcase
            pin_oe[i] = (sel == SRC_MCELL) ? (dir[i] & mc_oe[i]) : dir[i];
        end
    end
endmodule

// File: rtl/mio_port.sv
`timescale 1ns/1ps
module mio_port import mio_pkg::*; #(
    parameter int PORT_W = 8,
    parameter int ADDR_W = 3,
    parameter int XCS_W  = 2,
    parameter int SYNC_N = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [2*PORT_W-1:0] bus_wdata,
    output logic [2*PORT_W-1:0] bus_rdata,
    input  logic                ale,
    input  logic [PORT_W-1:0]   mux_addr,
    input  logic [PORT_W-1:0]   mc_out,
    input  logic [PORT_W-1:0]   mc_oe,
    input  logic [XCS_W-1:0]    ext_cs,
    input  logic [PORT_W-1:0]   pin_in,
    output logic [PORT_W-1:0]   pin_out,
    output logic [PORT_W-1:0]   pin_oe
);
    localparam int BUS_W = 2 * PORT_W;

    logic [BUS_W-1:0]  ctrl_q;
    logic [PORT_W-1:0] dout_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] lat_addr;
    logic [PORT_W-1:0] pin_sync;

    mio_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    mio_addr_latch #(.W(PORT_W)) u_lat (
        .clk(clk), .rst_n(rst_n), .ale(ale),
        .addr_in(mux_addr), .addr_out(lat_addr)
    );

    mio_regs #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .pin_sync(pin_sync), .mc_out(mc_out),
        .ctrl_q(ctrl_q), .dout_q(dout_q), .dir_q(dir_q),
        .bus_rdata(bus_rdata)
    );

    mio_pinmux #(.PORT_W(PORT_W), .XCS_W(XCS_W)) u_mux (
        .ctrl(ctrl_q), .dout(dout_q), .dir(dir_q), .lat_addr(lat_addr),
        .mc_out(mc_out), .mc_oe(mc_oe), .ext_cs(ext_cs),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );
endmodule

// File: rtl/mio_port_chk.sv
`timescale 1ns/1ps
module mio_port_chk #(
    parameter int PW = 8,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [2*PW-1:0] bus_wdata,
    input logic [2*PW-1:0] bus_rdata,
    input logic          ale,
    input logic [PW-1:0] mux_addr,
    input logic          ext_cs0,
    input logic [PW-1:0] pin_out,
    input logic [PW-1:0] pin_oe,
    input logic [2*PW-1:0] ctrl_q,
    input logic [PW-1:0] dout_q,
    input logic [PW-1:0] dir_q,
    input logic [PW-1:0] lat_addr
);
    p_oe_needs_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~dir_q) == '0);

    p_ro_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == AW'(0) || bus_addr >= AW'(4)))
        |=> ($stable(ctrl_q) && $stable(dout_q) && $stable(dir_q)));

    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(1)) |=> (ctrl_q == $past(bus_wdata)));

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > AW'(4)) |=> (bus_rdata == '0));

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (lat_addr == $past(mux_addr)));

    p_xcs_pin0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1:0] == 2'b11) |-> (pin_out[0] == ext_cs0));

    p_xcs_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[2*PW-1 -: 2] == 2'b11) |-> (pin_out[PW-1] == dout_q[PW-1]));
endmodule

bind mio_port mio_port_chk #(.PW(PORT_W), .AW(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ale(ale), .mux_addr(mux_addr), .ext_cs0(ext_cs[0]),
    .pin_out(pin_out), .pin_oe(pin_oe), .ctrl_q(ctrl_q),
    .dout_q(dout_q), .dir_q(dir_q), .lat_addr(lat_addr)
);

// File: tb/sim_mio_port.sv
`timescale 1ns/1ps
module sim_mio_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  bus_addr;
    logic        bus_wr, bus_rd, ale;
    logic [15:0] bus_wdata, bus_rdata;
    logic [7:0]  mux_addr, mc_out, mc_oe, pin_in, pin_out, pin_oe;
    logic [1:0]  ext_cs;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mio_port u0 (.*);

    // behavioural reference model
    logic [15:0] m_ctrl, m_rdata;
    logic [7:0]  m_dout, m_dir, m_held;
    logic [7:0]  m_hist[$];

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_pins(bit want_oe);
        logic [7:0] o, e;
        logic [7:0] lat;
        lat = ale ? mux_addr : m_held;
        for (int i = 0; i < 8; i++) begin
            int f;
            f = (m_ctrl >> (2*i)) & 3;
            e[i] = m_dir[i];
            if (f == 0) o[i] = m_dout[i];
            else if (f == 1) o[i] = lat[i];
            else if (f == 2) begin o[i] = mc_out[i]; e[i] = m_dir[i] & mc_oe[i]; end
            else o[i] = (i < 2) ? ext_cs[i] : m_dout[i];
        end
        return want_oe ? {8'h00, e} : {8'h00, o};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_dout = 0; m_dir = 0; m_held = 0; m_rdata = 0;
            m_hist = '{8'h00, 8'h00};
        end else begin
            if (bus_rd) begin
                case (bus_addr)
                    3'd0: m_rdata = {8'h00, m_hist[0]};
                    3'd1: m_rdata = m_ctrl;
                    3'd2: m_rdata = {8'h00, m_dout};
                    3'd3: m_rdata = {8'h00, m_dir};
                    3'd4: m_rdata = {8'h00, mc_out};
                    default: m_rdata = 0;
                endcase
            end
            if (bus_wr) begin
                case (bus_addr)
                    3'd1: m_ctrl = bus_wdata;
                    3'd2: m_dout = bus_wdata[7:0];
                    3'd3: m_dir  = bus_wdata[7:0];
                    default: ;
                endcase
            end
            void'(m_hist.pop_front());
            m_hist.push_back(pin_in);
            if (ale) m_held = mux_addr;
        end
        #1;
        if (!done) begin
            check("R2/R10 model rdata", bus_rdata, m_rdata);
            check("R6/R7/R8/R9 model pin_out", {8'h00, pin_out}, exp_pins(0));
            check("R5/R8 model pin_oe", {8'h00, pin_oe}, exp_pins(1));
        end
    end

    // every task starts and ends just after a falling edge
    task automatic wr(logic [2:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1;
        @(posedge clk); #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] r;
        rst_n = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
        ale = 0; mux_addr = 0; mc_out = 0; mc_oe = 0; ext_cs = 0; pin_in = 0;
        repeat (3) @(posedge clk);
        #1 check("R1 oe in reset", {8'h00, pin_oe}, 16'h0);
        check("R1 rdata in reset", bus_rdata, 16'h0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);

        rd(3'd1, r); check("R1 ctrl after reset", r, 16'h0);
        rd(3'd2, r); check("R1 dout after reset", r, 16'h0);
        rd(3'd3, r); check("R1 dir after reset", r, 16'h0);
        rd(3'd0, r); check("R1 sync after reset", r, 16'h0);

        // R6 / R5: data-out mode
        wr(3'd2, 16'hFFA5);
        wr(3'd3, 16'h00FF);
        settle();
        check("R6 dout on pins", {8'h00, pin_out}, 16'h00A5);
        check("R5 oe follows dir", {8'h00, pin_oe}, 16'h00FF);
        rd(3'd2, r); check("R2 dout readback zero-extended", r, 16'h00A5);
        @(negedge clk);
        check("R2 rdata holds without strobe", bus_rdata, 16'h00A5);

        // R3: writes to read-only / unmapped offsets
        wr(3'd0, 16'h1234); wr(3'd4, 16'h5678); wr(3'd6, 16'h9ABC); wr(3'd7, 16'hFFFF);
        rd(3'd1, r); check("R3 ctrl unchanged", r, 16'h0);
        rd(3'd2, r); check("R3 dout unchanged", r, 16'h00A5);
        rd(3'd3, r); check("R3 dir unchanged", r, 16'h00FF);

        // R4
        rd(3'd5, r); check("R4 offset 5 reads zero", r, 16'h0);
        rd(3'd7, r); check("R4 offset 7 reads zero", r, 16'h0);

        // R7: address capture
        wr(3'd1, 16'h5555);
        rd(3'd1, r); check("R2 ctrl readback", r, 16'h5555);
        ale = 1; mux_addr = 8'h3C; settle();
        check("R7 transparent", {8'h00, pin_out}, 16'h003C);
        @(negedge clk); mux_addr = 8'h81; settle();
        check("R7 follows while open", {8'h00, pin_out}, 16'h0081);
        @(negedge clk); ale = 0; mux_addr = 8'hFF; settle();
        check("R7 holds after strobe drops", {8'h00, pin_out}, 16'h0081);
        @(negedge clk);

        // R8: macrocell mode
        wr(3'd1, 16'hAAAA);
        mc_out = 8'h5A; mc_oe = 8'h0F; settle();
        check("R8 macrocell value", {8'h00, pin_out}, 16'h005A);
        check("R8 oe is dir and product term", {8'h00, pin_oe}, 16'h000F);
        wr(3'd3, 16'h00F0); settle();
        check("R8 oe gated by dir", {8'h00, pin_oe}, 16'h0000);
        rd(3'd4, r); check("R10 macrocell readback", r, 16'h005A);
        wr(3'd3, 16'h00FF);

        // R9: chip-select mode
        wr(3'd1, 16'hFFFF);
        ext_cs = 2'b10; settle();
        check("R9 cs on pins 0,1 and fallback", {8'h00, pin_out}, 16'h00A6);
        @(negedge clk); ext_cs = 2'b01; settle();
        check("R9 cs swapped", {8'h00, pin_out}, 16'h00A5);
        @(negedge clk);

        // mixed per-pin modes: pin0 dout, pin1 addr, pin2 macro, pin3 cs
        wr(3'd1, 16'h00E4);
        ale = 1; mux_addr = 8'h00; mc_out = 8'h04; mc_oe = 8'hFF; settle();
        check("R6/R7/R8/R9 mixed modes", {8'h00, pin_out}, 16'h00A5);
        @(negedge clk); ale = 0;
        wr(3'd3, 16'h000F); wr(3'd1, 16'h0000); settle();
        check("R5 partial direction", {8'h00, pin_oe}, 16'h000F);

        // R10: pin input through two flops then read register
        pin_in = 8'h3C;
        rd(3'd0, r); check("R10 first edge old value", r, 16'h0000);
        rd(3'd0, r); check("R10 second edge old value", r, 16'h0000);
        rd(3'd0, r); check("R10 third edge new value", r, 16'h003C);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule